// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries an 8-bit CPU core into and out of maskable interrupt service. The core tells it where instruction boundaries fall and hands it the live PC, A, X and CCR values. When a request is pending, the boundary strobe is high and the interrupt mask is clear, the block takes over a byte-wide memory port. It pushes a five-byte frame onto the stack, sets the mask, and reads the service vector of the winning source into the PC.

On a return request it reads the same frame back in reverse order and restores CCR, A, X and PC. The I bit comes back with the CCR byte. The stack pointer and the I bit live inside the block. The index-high register is never part of the frame. Memory reads are combinational: read data is valid in the same cycle as the address.

Top module: `int_seq_top`

## Requirements
- R1: After reset `i_mask_o`=1, `sp_o`=SP_RST (0x00FF), `busy_o`=0, and a pending request with a boundary strobe starts no sequence while the mask is 1.
- R2: A request is accepted only in a cycle with `boundary_i`=1 while idle. With `boundary_i`=0, pending requests start nothing.
- R3: Entry performs exactly five memory writes, each at the current SP, with SP decremented after each write. No other address is written and no index-high byte is stored.
- R4: The frame is written as PC low byte at SP0, PC high at SP0-1, X at SP0-2, A at SP0-3, and CCR at SP0-4; afterwards SP = SP0-5. The stacked CCR holds the mask value from before entry in bit 3, with the other bits taken from `ccr_i`.
- R5: The mask (bit 3 of `ccr_o`, and `i_mask_o`) becomes 1 only after the CCR byte has been written.
- R6: The lowest-numbered pending line wins. Its vector high byte is read at VEC_BASE-2*index (0xFFFE-2*index) and its low byte at the next address. `pc_o` = {high, low} when `done_o` pulses.
- R7: On `rti_i` the block increments SP before each of five reads, which return CCR, A, X, PC high and PC low. It then presents them on `ccr_o`, `a_o`, `x_o` and `pc_o`, `i_mask_o` takes bit 3 of the restored CCR, and SP returns to its value before entry.
- R8: `busy_o` is high for exactly 7 cycles on entry and 5 cycles on return. `done_o` pulses for one cycle in the cycle after the last busy cycle. A write and a read are never issued in the same cycle.
- R9: While `busy_o` is high, changes on `irq_i`, `boundary_i` and `rti_i` have no effect on the frame, the vector fetched or the cycle count.
- R10: `cli_i` held for one cycle while idle clears the mask, so that a nested entry pushes a frame whose CCR bit 3 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | N_IRQ | Pending maskable requests, line 0 highest |
| boundary_i | input | 1 | Instruction boundary strobe |
| rti_i | input | 1 | Return-from-interrupt request |
| cli_i | input | 1 | Clear interrupt mask |
| pc_i | input | AW | Address of next instruction |
| a_i | input | 8 | Accumulator |
| x_i | input | 8 | Index register low |
| ccr_i | input | 8 | Condition code register (bit 3 ignored) |
| mem_rdata_i | input | 8 | Memory read data, same cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| pc_o | output | AW | Vector or restored PC |
| a_o | output | 8 | Restored A |
| x_o | output | 8 | Restored X |
| ccr_o | output | 8 | Current CCR with mask |
| i_mask_o | output | 1 | Interrupt mask bit |
| sp_o | output | AW | Stack pointer |

## Verification
An entry accepted at clock edge E shows `busy_o` from the next cycle through seven cycles; a return shows it for five. `done_o` and the restored or vector outputs are valid in the cycle after the last busy cycle. The bench drives inputs and samples outputs on falling edges. It counts busy cycles until `done_o` appears and checks every result in that `done_o` cycle. Stack contents and the write count are checked at the same point, against a bench memory and a bench model of SP and mask.

// File: rtl/int_seq_pkg.sv
package int_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PUSH, S_VEC_HI, S_VEC_LO, S_POP
  } seq_state_e;
  localparam int FRAME_LEN = 5;
  localparam int I_POS     = 3;
  localparam int STEP_W    = 3;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        valid_o = 1'b1;
        idx_o   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/stack_ptr.sv
module stack_ptr #(
  parameter int          AW  = 16,
  parameter logic [AW-1:0] RST = 'h00FF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_i,
  input  logic          inc_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] sp_next_o
);
  assign sp_next_o = sp_o + AW'(1);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_o <= RST;
    else if (dec_i) sp_o <= sp_o - AW'(1);
    else if (inc_i) sp_o <= sp_next_o;
  end
endmodule

// File: rtl/int_seq_top.sv
module int_seq_top
  import int_seq_pkg::*;
#(
  parameter int            N_IRQ    = 8,
  parameter int            AW       = 16,
  parameter logic [AW-1:0] SP_RST   = 'h00FF,
  parameter logic [AW-1:0] VEC_BASE = 'hFFFE,
  localparam int           IW       = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             boundary_i,
  input  logic             rti_i,
  input  logic             cli_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [7:0]       a_i,
  input  logic [7:0]       x_i,
  input  logic [7:0]       ccr_i,
  input  logic [7:0]       mem_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             mem_we_o,
  output logic             mem_re_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  output logic [AW-1:0]    pc_o,
  output logic [7:0]       a_o,
  output logic [7:0]       x_o,
  output logic [7:0]       ccr_o,
  output logic             i_mask_o,
  output logic [AW-1:0]    sp_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(FRAME_LEN - 1);

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [AW-1:0]     pc_q;
  logic [7:0]        a_q, x_q, ccr_q;
  logic [IW-1:0]     vec_idx_q;
  logic              i_q, done_q;

  logic          req_valid;
  logic [IW-1:0] req_idx;
  logic [AW-1:0] sp, sp_next, vec_addr;
  logic          accept, start_rti;

  irq_prio_enc #(.N(N_IRQ)) i_enc (
    .req_i(irq_i), .valid_o(req_valid), .idx_o(req_idx)
  );

  stack_ptr #(.AW(AW), .RST(SP_RST)) i_sp (
    .clk_i, .rst_ni,
    .dec_i(state_q == S_PUSH),
    .inc_i(state_q == S_POP),
    .sp_o(sp), .sp_next_o(sp_next)
  );

  assign start_rti = (state_q == S_IDLE) && rti_i;
  assign accept    = (state_q == S_IDLE) && !rti_i && boundary_i && req_valid && !i_q;
  assign vec_addr  = VEC_BASE - (AW'(vec_idx_q) << 1);

  always_comb begin
    mem_we_o    = (state_q == S_PUSH);
    mem_re_o    = (state_q == S_VEC_HI) || (state_q == S_VEC_LO) || (state_q == S_POP);
    mem_addr_o  = sp;
    mem_wdata_o = ccr_q;
    unique case (state_q)
      S_VEC_HI: mem_addr_o = vec_addr;
      S_VEC_LO: mem_addr_o = vec_addr + AW'(1);
      S_POP:    mem_addr_o = sp_next;
      default:  mem_addr_o = sp;
    endcase
    case (step_q)
      3'd0:    mem_wdata_o = pc_q[7:0];
      3'd1:    mem_wdata_o = pc_q[15:8];
      3'd2:    mem_wdata_o = x_q;
      3'd3:    mem_wdata_o = a_q;
      default: mem_wdata_o = ccr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      step_q    <= '0;
      pc_q      <= '0;
      a_q       <= '0;
      x_q       <= '0;
      ccr_q     <= 8'h08;
      vec_idx_q <= '0;
      i_q       <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          step_q <= '0;
          if (start_rti) begin
            state_q <= S_POP;
          end else if (accept) begin
            pc_q      <= pc_i;
            a_q       <= a_i;
            x_q       <= x_i;
            ccr_q     <= ccr_i;
            ccr_q[I_POS] <= i_q;
            vec_idx_q <= req_idx;
            state_q   <= S_PUSH;
          end else if (cli_i) begin
            i_q          <= 1'b0;
            ccr_q[I_POS] <= 1'b0;
          end
        end
        S_PUSH: begin
          step_q <= step_q + 1'b1;
          if (step_q == LAST) begin
            i_q          <= 1'b1;
            ccr_q[I_POS] <= 1'b1;
            state_q      <= S_VEC_HI;
          end
        end
        S_VEC_HI: begin
          pc_q[15:8] <= mem_rdata_i;
          state_q    <= S_VEC_LO;
        end
        S_VEC_LO: begin
          pc_q[7:0] <= mem_rdata_i;
          done_q    <= 1'b1;
          state_q   <= S_IDLE;
        end
        S_POP: begin
          step_q <= step_q + 1'b1;
          case (step_q)
            3'd0: begin ccr_q <= mem_rdata_i; i_q <= mem_rdata_i[I_POS]; end
            3'd1: a_q <= mem_rdata_i;
            3'd2: x_q <= mem_rdata_i;
            3'd3: pc_q[15:8] <= mem_rdata_i;
            default: begin
              pc_q[7:0] <= mem_rdata_i;
              done_q    <= 1'b1;
              state_q   <= S_IDLE;
            end
          endcase
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = done_q;
  assign pc_o     = pc_q;
  assign a_o      = a_q;
  assign x_o      = x_q;
  assign ccr_o    = ccr_q;
  assign i_mask_o = i_q;
  assign sp_o     = sp;
endmodule

// File: rtl/int_seq_chk.sv
module int_seq_chk #(
  parameter int AW = 16,
  parameter int IW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic [AW-1:0] sp_o,
  input logic          i_mask_o,
  input logic [2:0]    state_i,
  input logic [2:0]    step_i,
  input logic [IW-1:0] vec_idx_i
);
  // state 1 = push, 4 = pop (package enum order)
  assert_push_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> sp_o == $past(sp_o) - AW'(1));

  assert_pop_inc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && state_i == 3'd4) |=> sp_o == $past(sp_o) + AW'(1));

  assert_mask_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && step_i == 3'd4) |=> i_mask_o);

  assert_mask_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && step_i != 3'd4) |=> $stable(i_mask_o));

  assert_rw_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_idx_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(vec_idx_i));
endmodule

bind int_seq_top int_seq_chk #(.AW(AW), .IW(IW)) i_chk (
  .clk_i, .rst_ni, .busy_o, .done_o, .mem_we_o, .mem_re_o, .sp_o, .i_mask_o,
  .state_i(state_q), .step_i(step_q), .vec_idx_i(vec_idx_q)
);

// File: tb/test_int_seq_top.sv
module test_int_seq_top;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq = '0;
  logic boundary = 0, rti = 0, cli = 0;
  logic [15:0] pc_in = '0;
  logic [7:0] a_in = '0, x_in = '0, ccr_in = '0, rdata;
  logic busy, done, we, re, imask;
  logic [15:0] addr, pc_out, sp;
  logic [7:0] wdata, a_out, x_out, ccr_out;

  int checks = 0, errors = 0, writes = 0, bad_wr = 0;
  logic [7:0] mem [0:255];

  always #10 clk = ~clk;

  int_seq_top i_int_seq_top (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .boundary_i(boundary), .rti_i(rti),
    .cli_i(cli), .pc_i(pc_in), .a_i(a_in), .x_i(x_in), .ccr_i(ccr_in),
    .mem_rdata_i(rdata), .busy_o(busy), .done_o(done), .mem_we_o(we), .mem_re_o(re),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .pc_o(pc_out), .a_o(a_out), .x_o(x_out),
    .ccr_o(ccr_out), .i_mask_o(imask), .sp_o(sp)
  );

  function automatic logic [7:0] rom(input logic [15:0] ad);
    return ad[7:0] ^ 8'h5A;
  endfunction
  assign rdata = (addr[15:8] == 8'h00) ? mem[addr[7:0]] : rom(addr);

  always @(posedge clk) if (we) begin
    writes <= writes + 1;
    if (addr[15:8] != 8'h00) bad_wr <= bad_wr + 1;
    else mem[addr[7:0]] <= wdata;
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int prio(input logic [N-1:0] r);
    for (int k = N - 1; k >= 0; k--) if (r[k]) prio = k;
  endfunction

  logic [15:0] sp_m;
  logic        i_m;

  task automatic wait_done(input bit noise, output int nbusy);
    nbusy = 0;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (done) begin
        boundary = 0; rti = 0; irq = '0;
        return;
      end
      if (busy) nbusy++;
      if (noise) begin
        irq = N'($urandom); boundary = 1'($urandom); rti = 1'($urandom);
      end
    end
  endtask

  task automatic do_cli;
    @(negedge clk); cli = 1;
    @(negedge clk); cli = 0;
    i_m = 0;
    chk(imask == 0, "R10 cli clears mask", imask, 0);
  endtask

  task automatic do_entry(input bit noise);
    logic [N-1:0] r;
    logic [15:0] va, exp_pc;
    logic [7:0] exp_ccr;
    int nb, w0, idx;
    r = N'($urandom) | N'(1 << ($urandom % N));
    pc_in = 16'($urandom); a_in = 8'($urandom); x_in = 8'($urandom); ccr_in = 8'($urandom);
    idx = prio(r);
    va = 16'hFFFE - 16'(2 * idx);
    exp_pc = {rom(va), rom(va + 16'd1)};
    exp_ccr = ccr_in; exp_ccr[3] = i_m;
    w0 = writes;
    @(negedge clk); irq = r; boundary = 1;
    @(negedge clk); boundary = 0;
    chk(busy == 1, "R2 accepted on boundary", busy, 1);
    wait_done(noise, nb);
    nb++;
    chk(nb == 7, "R8 entry busy cycles", nb, 7);
    chk(done == 1, "R8 done pulse", done, 1);
    chk(writes - w0 == 5, "R3 five writes", writes - w0, 5);
    chk(mem[sp_m[7:0]] == pc_in[7:0], "R4 PCL slot", mem[sp_m[7:0]], pc_in[7:0]);
    chk(mem[8'(sp_m - 1)] == pc_in[15:8], "R4 PCH slot", mem[8'(sp_m - 1)], pc_in[15:8]);
    chk(mem[8'(sp_m - 2)] == x_in, "R4 X slot", mem[8'(sp_m - 2)], x_in);
    chk(mem[8'(sp_m - 3)] == a_in, "R4 A slot", mem[8'(sp_m - 3)], a_in);
    chk(mem[8'(sp_m - 4)] == exp_ccr, "R4 CCR slot", mem[8'(sp_m - 4)], exp_ccr);
    sp_m = sp_m - 16'd5;
    chk(sp == sp_m, "R4 sp after push", sp, sp_m);
    chk(pc_out == exp_pc, "R6 vector pc", pc_out, exp_pc);
    i_m = 1;
    chk(imask == 1 && ccr_out[3] == 1, "R5 mask set", imask, 1);
    @(negedge clk);
    chk(done == 0 && busy == 0, "R8 done one cycle", {busy, done}, 0);
  endtask

  task automatic do_rti(input bit noise, input bit force_i);
    logic [7:0] e_ccr, e_a, e_x;
    logic [15:0] e_pc;
    int nb;
    if (force_i) mem[8'(sp_m + 1)][3] = 1'b1;
    e_ccr = mem[8'(sp_m + 1)]; e_a = mem[8'(sp_m + 2)]; e_x = mem[8'(sp_m + 3)];
    e_pc = {mem[8'(sp_m + 4)], mem[8'(sp_m + 5)]};
    @(negedge clk); rti = 1;
    @(negedge clk); rti = 0;
    wait_done(noise, nb);
    nb++;
    chk(nb == 5, "R8 rti busy cycles", nb, 5);
    chk(ccr_out == e_ccr, "R7 ccr restore", ccr_out, e_ccr);
    chk(a_out == e_a, "R7 a restore", a_out, e_a);
    chk(x_out == e_x, "R7 x restore", x_out, e_x);
    chk(pc_out == e_pc, "R7 pc restore", pc_out, e_pc);
    sp_m = sp_m + 16'd5;
    chk(sp == sp_m, "R7 sp restore", sp, sp_m);
    i_m = e_ccr[3];
    chk(imask == i_m, "R7 mask from stack", imask, i_m);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 256; k++) mem[k] = 8'h00;
    sp_m = 16'h00FF; i_m = 1;
    #35 rst_n = 1;
    @(negedge clk);
    chk(imask == 1, "R1 reset mask", imask, 1);
    chk(sp == 16'h00FF, "R1 reset sp", sp, 16'h00FF);
    chk(busy == 0, "R1 reset idle", busy, 0);
    // masked request ignored
    irq = 8'h81; boundary = 1;
    repeat (3) @(negedge clk);
    chk(busy == 0 && writes == 0, "R1 masked request", busy, 0);
    boundary = 0;
    do_cli();
    // no boundary: nothing starts
    repeat (3) @(negedge clk);
    chk(busy == 0 && writes == 0, "R2 no boundary", busy, 0);
    irq = '0;
    for (int it = 0; it < 24; it++) begin
      if (i_m) do_cli();
      do_entry(it % 2 == 1);
      if (it % 3 == 0) begin
        do_cli();
        do_entry(1'b0);
        do_rti(1'b1, 1'b0);
      end
      do_rti(it % 2 == 0, it == 5);
    end
    chk(bad_wr == 0, "R3 no stray writes", bad_wr, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule